// File: doc/BRIEF.md
# Ancillary Data Packet Formatter

This block assembles one user-defined ancillary packet as a stream of 10-bit words, ready for insertion into a digital video stream. A one-cycle `start` pulse begins a packet. The block then emits a three-word start marker of its own. It follows this with a type word, built from an 8-bit configuration value with two protection bits that the block computes. Next it relays the caller's sub-type word, count word and payload words from a valid/ready input stream. It ends the packet with a checksum word that it computes itself.

The output is a valid/ready stream, and `out_ready` is the only back-pressure. During the words the block generates itself, `in_ready` stays low and `out_valid` is high. During the sub-type, count and payload words, the input passes straight through with no latency. In those phases `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so a word moves from input to output in the cycle where both sides handshake. The block can take at most 255 caller words per packet, which leaves room for 253 payload words. A larger count truncates the payload and sets a sticky overflow flag.

Top module: `anc_pkt_fmt`

## Requirements
- R1: After a start pulse in idle, the first three output words are 0x000, 0x3FF and 0x3FF, in that order.
- R2: The fourth word is {~p, p, cfg_id}, where p is the XOR of cfg_id[7:0]. Bits 8..0 then have even parity.
- R3: Sub-type and count words whose input bits 9:8 are both zero go out with bits 9:8 replaced by the same protection as R2. With any other value in bits 9:8 they pass unchanged. Payload words always pass unchanged.
- R4: The count word's bits 7:0 give the number N of payload words that follow. N = 0 goes straight to the checksum.
- R5: If N exceeds 253, exactly 253 payload words are taken and `ovf` rises after the count word transfers. `ovf` stays high until reset.
- R6: Let S be the 9-bit sum of bits 8..0 of every output word from the type word through the last payload word. The final word is {~S[8], S}.
- R7: A word transfers only when `out_valid` and `out_ready` are both high. `in_ready` is high only in the sub-type, count and payload phases, and there it equals `out_ready`. In those phases `out_valid` equals `in_valid`. In every other busy phase `out_valid` is high.
- R8: `done` is high for exactly one cycle, the cycle after the checksum word transfers.
- R9: A start pulse while a packet is in progress has no effect.
- R10: During and after reset, `out_valid`, `in_ready`, `done` and `ovf` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a packet (taken only when idle) |
| cfg_id | input | 8 | Type value for the packet; held stable for the whole packet |
| in_data | input | 10 | Caller word: sub-type, count, then payload |
| in_valid | input | 1 | Caller word present |
| in_ready | output | 1 | Caller word accepted this cycle when in_valid is high |
| out_word | output | 10 | Packet word |
| out_valid | output | 1 | Packet word present |
| out_ready | input | 1 | Downstream accepts the word |
| done | output | 1 | One-cycle pulse after the checksum word |
| ovf | output | 1 | Sticky payload-truncation flag |

## Verification
The stall-stability property assumes an AXI-style source. Once it raises `in_valid`, it holds both `in_valid` and `in_data` until the word is taken, because in pass-through phases the output word is the input word. The input driver follows this rule. It inserts idle gaps only between accepted words and changes data only after a handshake edge. The downstream side stalls from a pseudo-random pattern, so back-pressure arrives in every phase, including the generated marker and checksum words.

// File: rtl/anc_pkt_pkg.sv
package anc_pkt_pkg;
  localparam int ANC_W = 10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FLAG0, ST_FLAG1, ST_FLAG2, ST_ID, ST_SUB, ST_CNT, ST_PAY, ST_SUM
  } anc_state_e;

  function automatic logic [ANC_W-1:0] anc_protect(input logic [7:0] b);
    logic p;
    p = ^b;
    return {~p, p, b};
  endfunction
endpackage

// File: rtl/anc_seq.sv
module anc_seq
  import anc_pkt_pkg::*;
#(
  parameter int MAX_IN = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fire,
  input  logic [7:0] cnt_in,
  output anc_state_e state,
  output logic       ovf,
  output logic       done
);
  localparam int MAX_PAY = MAX_IN - 2;
  localparam int CNT_W   = $clog2(MAX_IN + 1);

  logic [CNT_W-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      left  <= '0;
      ovf   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_FLAG0;
        ST_FLAG0: if (fire) state <= ST_FLAG1;
        ST_FLAG1: if (fire) state <= ST_FLAG2;
        ST_FLAG2: if (fire) state <= ST_ID;
        ST_ID:    if (fire) state <= ST_SUB;
        ST_SUB:   if (fire) state <= ST_CNT;
        ST_CNT: if (fire) begin
          if (int'(cnt_in) > MAX_PAY) begin
            left <= CNT_W'(MAX_PAY);
            ovf  <= 1'b1;
          end else begin
            left <= CNT_W'(cnt_in);
          end
          state <= (cnt_in == 8'd0) ? ST_SUM : ST_PAY;
        end
        ST_PAY: if (fire) begin
          left <= left - CNT_W'(1);
          if (left == CNT_W'(1)) state <= ST_SUM;
        end
        ST_SUM: if (fire) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/anc_fmt.sv
module anc_fmt
  import anc_pkt_pkg::*;
#(
  parameter bit FILL_PROT = 1'b1
) (
  input  anc_state_e       state,
  input  logic [7:0]       cfg_id,
  input  logic [ANC_W-1:0] in_data,
  input  logic [8:0]       sum,
  output logic [ANC_W-1:0] word
);
  logic [ANC_W-1:0] hdr_w;

  generate
    if (FILL_PROT) begin : g_fill
      assign hdr_w = (in_data[9:8] == 2'b00) ? anc_protect(in_data[7:0]) : in_data;
    end else begin : g_pass
      assign hdr_w = in_data;
    end
  endgenerate

  always_comb begin
    unique case (state)
      ST_FLAG0:       word = '0;
      ST_FLAG1,
      ST_FLAG2:       word = '1;
      ST_ID:          word = anc_protect(cfg_id);
      ST_SUB, ST_CNT: word = hdr_w;
      ST_PAY:         word = in_data;
      ST_SUM:         word = {~sum[8], sum};
      default:        word = '0;
    endcase
  end
endmodule

// File: rtl/anc_csum.sv
module anc_csum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       acc_en,
  input  logic [8:0] word_lo,
  output logic [8:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= '0;
    else if (clr)    sum <= '0;
    else if (acc_en) sum <= sum + word_lo;
  end
endmodule

// File: rtl/anc_pkt_fmt.sv
module anc_pkt_fmt
  import anc_pkt_pkg::*;
#(
  parameter int MAX_IN    = 255,
  parameter bit FILL_PROT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cfg_id,
  input  logic [ANC_W-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [ANC_W-1:0] out_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             ovf
);
  anc_state_e state;
  logic       fire, user_ph, acc_en, clr;
  logic       ph_did, ph_cs;
  logic [8:0] sum;

  assign user_ph   = (state == ST_SUB) || (state == ST_CNT) || (state == ST_PAY);
  assign out_valid = (state != ST_IDLE) && (!user_ph || in_valid);
  assign in_ready  = user_ph && out_ready;
  assign fire      = out_valid && out_ready;
  assign acc_en    = fire && ((state == ST_ID) || user_ph);
  assign clr       = start && (state == ST_IDLE);
  assign ph_did    = (state == ST_ID);
  assign ph_cs     = (state == ST_SUM);

  anc_seq #(.MAX_IN(MAX_IN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
    .cnt_in(in_data[7:0]), .state(state), .ovf(ovf), .done(done)
  );

  anc_fmt #(.FILL_PROT(FILL_PROT)) u_fmt (
    .state(state), .cfg_id(cfg_id), .in_data(in_data), .sum(sum), .word(out_word)
  );

  anc_csum u_csum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
    .word_lo(out_word[8:0]), .sum(sum)
  );
endmodule

// File: rtl/anc_pkt_fmt_chk.sv
module anc_pkt_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] out_word,
  input logic       out_valid,
  input logic       out_ready,
  input logic       in_valid,
  input logic       in_ready,
  input logic       done,
  input logic       ovf,
  input logic       ph_did,
  input logic       ph_cs
);
  p_in_xfer_has_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> out_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_type_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_did && out_valid) |-> ((^out_word[8:0]) == 1'b0 && out_word[9] != out_word[8]));

  p_sum_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_cs && out_valid) |-> (out_word[9] != out_word[8]));

  p_done_after_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ph_cs && out_valid && out_ready));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind anc_pkt_fmt anc_pkt_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_word(out_word), .out_valid(out_valid),
  .out_ready(out_ready), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .ovf(ovf), .ph_did(ph_did), .ph_cs(ph_cs)
);

// File: tb/sim_anc_pkt_fmt.sv
module sim_anc_pkt_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cfg_id = 8'h00;
  logic [9:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, done, ovf;
  logic [9:0] out_word;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic       stall_en = 1'b0, gap_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  // expected stream: kind 0 flag,1 type,2 sub,3 count,4 payload,5 checksum
  logic [9:0] q_w[$], stg_w[$], usr[$];
  int         q_k[$], stg_k[$];
  logic       done_due = 1'b0, ovf_exp = 1'b0;

  always #4 clk = ~clk;

  anc_pkt_fmt u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_id(cfg_id),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_word(out_word), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .ovf(ovf)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] prot(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return (ones % 2) ? 10'h100 | b : 10'h200 | b;
  endfunction

  function automatic string ktag(input int k);
    case (k)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R3";
      4: return "R4"; default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      int  sz;
      bit  usr_ph, fired;
      int  fk;
      logic [9:0] fw;
      sz = q_w.size();
      usr_ph = (sz > 0) && (q_k[0] >= 2 && q_k[0] <= 4);
      chk(out_valid == ((sz > 0) && (!usr_ph || in_valid)), "R7 out_valid", out_valid,
          (sz > 0) && (!usr_ph || in_valid));
      chk(in_ready == (usr_ph && out_ready), "R7 in_ready", in_ready, usr_ph && out_ready);
      chk(done == done_due, "R8 done", done, done_due);
      chk(ovf == ovf_exp, "R5 ovf", ovf, ovf_exp);
      fired = 1'b0; fk = 0; fw = '0;
      if (out_valid && out_ready && sz > 0) begin
        fw = q_w.pop_front(); fk = q_k.pop_front(); fired = 1'b1;
        chk(out_word == fw, ktag(fk), out_word, fw);
      end
      done_due = fired && fk == 5;
      if (fired && fk == 3 && fw[7:0] > 8'd253) ovf_exp = 1'b1;
      if (start && sz == 0) begin
        q_w = stg_w; q_k = stg_k;
      end
    end
  end

  task automatic send(input logic [9:0] w);
    if (gap_en && lfsr[1]) begin
      @(posedge clk); #2;
    end
    in_data = w; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic run_pkt(input logic [7:0] id, input logic [9:0] sub, input logic [9:0] cnt,
                         input bit extra_start);
    int n, s;
    logic [9:0] w;
    n = (cnt[7:0] > 8'd253) ? 253 : int'(cnt[7:0]);
    stg_w.delete(); stg_k.delete(); usr.delete();
    stg_w.push_back(10'h000); stg_k.push_back(0);
    stg_w.push_back(10'h3FF); stg_k.push_back(0);
    stg_w.push_back(10'h3FF); stg_k.push_back(0);
    stg_w.push_back(prot(id)); stg_k.push_back(1);
    stg_w.push_back(sub[9:8] == 2'b00 ? prot(sub[7:0]) : sub); stg_k.push_back(2);
    stg_w.push_back(cnt[9:8] == 2'b00 ? prot(cnt[7:0]) : cnt); stg_k.push_back(3);
    usr.push_back(sub); usr.push_back(cnt);
    for (int i = 0; i < n; i++) begin
      w = 10'($urandom_range(0, 1023));
      stg_w.push_back(w); stg_k.push_back(4); usr.push_back(w);
    end
    s = 0;
    for (int i = 3; i < stg_w.size(); i++) s = (s + int'(stg_w[i][8:0])) % 512;
    w = {~s[8], s[8:0]};
    stg_w.push_back(w); stg_k.push_back(5);
    @(posedge clk); #2;
    cfg_id = id; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (extra_start) begin
      fork
        begin
          repeat (7) @(posedge clk);
          #3; start = 1'b1;
          @(posedge clk); #3; start = 1'b0;
        end
      join_none
    end
    foreach (usr[i]) send(usr[i]);
    while (q_w.size() != 0) @(posedge clk);
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after packet", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 out_valid", out_valid, 0);
    chk(in_ready == 0, "R10 in_ready", in_ready, 0);
    chk(done == 0, "R10 done", done, 0);
    chk(ovf == 0, "R10 ovf", ovf, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    // R1 R2 R3 R4 R6: plain packet, no stalls
    run_pkt(8'h41, 10'h012, 10'h004, 1'b0);
    // R4: empty payload under stalls
    stall_en = 1'b1;
    run_pkt(8'hC3, 10'h0F0, 10'h000, 1'b0);
    // R3: caller-set top bits pass through, gaps and stalls
    gap_en = 1'b1;
    run_pkt(8'h00, 10'h2A7, 10'h105, 1'b0);
    // R9: start pulse while busy
    run_pkt(8'hFF, 10'h001, 10'h00A, 1'b1);
    // R5: count above limit truncates, flag stays
    gap_en = 1'b0;
    run_pkt(8'h7E, 10'h033, 10'h0FF, 1'b0);
    run_pkt(8'h15, 10'h044, 10'h002, 1'b0);
    chk(ovf == 1'b1, "R5 sticky", ovf, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule